// File: doc/BRIEF.md
# Multi-Mode Asynchronous Host Port Slave

This block is the host-facing slave port of a peripheral. An external host reaches a small register file through a 2-bit address and an 8-bit data bus. The bus is split here into an input byte, an output byte and an output enable. The host's control lines are asynchronous to the block clock. The strobes and the select are passed through a two-flop synchroniser, and then through an edge detector. Every transfer is a fully interlocked four-phase handshake: the strobe falls, the slave acknowledges, the strobe rises, and the slave withdraws the acknowledge.

Three signalling schemes share the same pins, and the scheme is chosen at reset.
- **Data-strobe schemes.** One line gives the direction and a single strobe times the transfer.
- **Split-strobe scheme.** An active-low select qualifies separate read and write strobes, and the acknowledge pin serves as a ready output.

The acknowledge pin is driven only while the select is low.

Behind the port sit two general-purpose bytes, a pending-interrupt byte whose bits are cleared by writing 1, and a configuration byte. The interrupt pin is active low. By default it behaves as open-drain; one configuration bit makes it push-pull.

Top module: `hpslv_port`

## Requirements
- R1: `mode_sel` is captured while `rst` is high. The codes are: 0 = data strobe with acknowledge, 1 = split strobes, 2 = data strobe with ready, 3 = treated as 1. Changing `mode_sel` after reset has no effect.
- R2: In the data-strobe schemes, a cycle starts when `ds_rd_n` falls. `rw_wr_n` high selects a read and low selects a write. A write stores `data_in` at `addr`.
- R3: `ack_out` goes low on the third rising clock edge after the starting strobe edge, and not before.
- R4: `ack_out` stays low until the strobe is released. It returns high on the third rising edge after the release. In the split scheme, release means both strobes are high.
- R5: In the split scheme, `ds_rd_n` is the read strobe and `rw_wr_n` is the write strobe. Strobes arriving while `cs_n` is high are ignored.
- R6: `ack_oe` is 1 exactly while `cs_n` is 0.
- R7: `data_oe` is 1 only when all of these hold: a read cycle is active, `ack_out` is low, `cs_n` is low and `ds_rd_n` is low. `data_out` then carries the addressed register.
- R8: In mode 0, cycles run even with `cs_n` high; writes take effect and the acknowledge stays undriven. In mode 2, cycles need `cs_n` low.
- R9: The register map is: address 0 and address 1 are general bytes, address 2 is the pending byte, address 3 is the configuration byte. All four reset to 0.
- R10: A 1 on `irq_event[i]` for one clock sets pending bit i. Writing 1 to bit i at address 2 clears it. A set in the same cycle as a clear wins.
- R11: The interrupt pin is active low.
  - When configuration bit 0 is 0 (open-drain), `irq_oe` equals the OR of the pending bits and `irq_out` is 0.
  - When configuration bit 0 is 1 (push-pull), `irq_oe` is 1 and `irq_out` is the inverse of that OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; `mode_sel` is captured while it is high |
| mode_sel | input | 2 | Signalling scheme code |
| cs_n | input | 1 | Active-low select (asynchronous) |
| rw_wr_n | input | 1 | Read/write line, or write strobe in the split scheme |
| ds_rd_n | input | 1 | Data strobe, or read strobe in the split scheme |
| addr | input | 2 | Register address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data to the host |
| data_oe | output | 1 | Drive enable for the data bus |
| ack_out | output | 1 | Acknowledge/ready, active low |
| ack_oe | output | 1 | Drive enable for the acknowledge pin |
| irq_event | input | 8 | Interrupt source pulses, one per pending bit |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
The assertions assume that the host holds `addr`, `rw_wr_n` and `data_in` steady from the strobe edge until it sees the acknowledge. They also assume that no new strobe is started before the acknowledge has been withdrawn. The bench keeps within these limits by changing inputs only on falling clock edges. Each bus task holds the whole cycle until `ack_out` has been released. `mode_sel` is changed only around a reset, apart from one deliberate change after reset that shows the change is ignored.

// File: rtl/hpslv_pkg.sv
package hpslv_pkg;

    localparam int HP_DATA_W = 8;
    localparam int HP_ADDR_W = 2;
    localparam int HP_NUM_GP = 2;

    localparam logic [HP_ADDR_W-1:0] REG_PEND = 2'd2;
    localparam logic [HP_ADDR_W-1:0] REG_CFG  = 2'd3;

    typedef enum logic [1:0] {
        MODE_DS_ACK = 2'd0,
        MODE_SPLIT  = 2'd1,
        MODE_DS_RDY = 2'd2,
        MODE_RSVD   = 2'd3
    } port_mode_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic cs_n;
        logic p1;
        logic p2;
    } pins_t;

    function automatic logic uses_split(port_mode_e m);
        return (m == MODE_SPLIT) || (m == MODE_RSVD);
    endfunction

    function automatic logic needs_select(port_mode_e m);
        return m != MODE_DS_ACK;
    endfunction

endpackage

// File: rtl/hpslv_sync.sv
module hpslv_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hpslv_hshake.sv
module hpslv_hshake
    import hpslv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_mode_e mode,
    input  pins_t      pins,
    output logic       start,
    output logic       start_wr,
    output logic       hold,
    output logic       hold_rd,
    output logic       done
);
    pins_t     prev_q;
    hs_state_e state_q;
    logic      rd_fall, wr_fall, go;

    always_comb begin
        rd_fall = prev_q.p2 & ~pins.p2;
        wr_fall = prev_q.p1 & ~pins.p1;
        if (uses_split(mode)) begin
            go       = ~pins.cs_n & (rd_fall | wr_fall);
            start_wr = wr_fall & ~rd_fall;
            done     = pins.p1 & pins.p2;
        end else begin
            go       = (~needs_select(mode) | ~pins.cs_n) & rd_fall;
            start_wr = ~pins.p1;
            done     = pins.p2;
        end
    end

    assign start = (state_q == HS_IDLE) & go;
    assign hold  = (state_q == HS_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '1;
            state_q <= HS_IDLE;
            hold_rd <= 1'b0;
        end else begin
            prev_q <= pins;
            case (state_q)
                HS_IDLE: if (go) begin
                    state_q <= HS_HOLD;
                    hold_rd <= ~start_wr;
                end
                HS_HOLD: if (done) state_q <= HS_IDLE;
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    // R4: once held, the cycle persists while the strobe is still active
    assert_hold_interlock_R4: assert property (@(posedge clk) disable iff (rst)
        (hold && !done) |=> hold);
endmodule

// File: rtl/hpslv_regs.sv
module hpslv_regs
    import hpslv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [HP_ADDR_W-1:0] addr,
    input  logic [HP_DATA_W-1:0] wdata,
    input  logic [HP_DATA_W-1:0] irq_event,
    output logic [HP_DATA_W-1:0] rdata,
    output logic                 pend_any,
    output logic                 cfg_pp
);
    logic [HP_DATA_W-1:0] gp_q [HP_NUM_GP];
    logic [HP_DATA_W-1:0] pend_q, cfg_q, clr_mask;

    for (genvar g = 0; g < HP_NUM_GP; g++) begin : g_gp
        always_ff @(posedge clk) begin
            if (rst)                                    gp_q[g] <= '0;
            else if (wr_en && addr == HP_ADDR_W'(g))    gp_q[g] <= wdata;
        end
    end

    assign clr_mask = (wr_en && addr == REG_PEND) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cfg_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | irq_event;
            if (wr_en && addr == REG_CFG) cfg_q <= wdata;
        end
    end

    always_comb begin
        case (addr)
            REG_PEND: rdata = pend_q;
            REG_CFG:  rdata = cfg_q;
            default:  rdata = gp_q[addr[0]];
        endcase
    end

    assign pend_any = |pend_q;
    assign cfg_pp   = cfg_q[0];

    // R10: an event pulse always leaves its bit pending
    assert_event_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (|irq_event) |=> ((pend_q & $past(irq_event)) == $past(irq_event)));
    // R10: a write of ones clears those bits when no event collides
    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_PEND && irq_event == '0) |=> ((pend_q & $past(wdata)) == '0));
endmodule

// File: rtl/hpslv_port.sv
module hpslv_port
    import hpslv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       cs_n,
    input  logic       rw_wr_n,
    input  logic       ds_rd_n,
    input  logic [1:0] addr,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       ack_out,
    output logic       ack_oe,
    input  logic [7:0] irq_event,
    output logic       irq_out,
    output logic       irq_oe
);
    port_mode_e           mode_q;
    pins_t                pins_raw, pins_s;
    logic                 start, start_wr, hold, hold_rd, done;
    logic                 pend_any, cfg_pp;
    logic [HP_DATA_W-1:0] rdata, rd_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= port_mode_e'(mode_sel);
    end

    assign pins_raw = '{cs_n: cs_n, p1: rw_wr_n, p2: ds_rd_n};

    hpslv_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    hpslv_hshake u_hshake (
        .clk(clk), .rst(rst), .mode(mode_q), .pins(pins_s),
        .start(start), .start_wr(start_wr), .hold(hold), .hold_rd(hold_rd), .done(done)
    );

    hpslv_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(start & start_wr), .addr(addr), .wdata(data_in),
        .irq_event(irq_event), .rdata(rdata), .pend_any(pend_any), .cfg_pp(cfg_pp)
    );

    always_ff @(posedge clk) begin
        if (rst)                     rd_q <= '0;
        else if (start && !start_wr) rd_q <= rdata;
    end

    assign ack_out  = ~hold;
    assign ack_oe   = ~cs_n;
    assign data_oe  = hold & hold_rd & ~cs_n & ~ds_rd_n;
    assign data_out = rd_q;
    assign irq_oe   = cfg_pp | pend_any;
    assign irq_out  = cfg_pp & ~pend_any;

    // R1: scheme does not change outside reset
    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));
    // R3: acknowledge only falls after a detected start
    assert_ack_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_out) |-> $past(start));
    // R4: acknowledge only rises after the strobe was seen released
    assert_ack_release_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_out) |-> $past(done));
    // R5: split scheme never starts a cycle while deselected
    assert_split_select_R5: assert property (@(posedge clk) disable iff (rst)
        (uses_split(mode_q) && pins_s.cs_n) |-> !start);
    // R7: data is driven only while the acknowledge is low
    assert_data_with_ack_R7: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !ack_out);
    // R11: open-drain mode never drives the pin high
    assert_open_drain_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg_pp |-> !(irq_oe && irq_out));
endmodule

// File: tb/hpslv_port_bench.sv
module hpslv_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'd0;
    logic       cs_n = 1'b1, rw_wr_n = 1'b1, ds_rd_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] data_in = 8'h00, irq_event = 8'h00;
    logic [7:0] data_out;
    logic       data_oe, ack_out, ack_oe, irq_out, irq_oe;

    int  checks = 0, errors = 0;
    bit  split_m = 0, model_on = 0, finished = 0;
    logic [7:0] pend_m = 0;
    logic       cfg_m = 0;

    always #2 clk = ~clk;

    hpslv_port u_hpslv_port (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n), .rw_wr_n(rw_wr_n),
        .ds_rd_n(ds_rd_n), .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .ack_out(ack_out), .ack_oe(ack_oe), .irq_event(irq_event),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison of pins the model fully determines
    always begin
        @(negedge clk);
        #1;
        if (model_on && !rst && !finished) begin
            check("R6 ack_oe", {31'b0, ack_oe}, {31'b0, ~cs_n});
            check("R11 irq_oe", {31'b0, irq_oe}, {31'b0, cfg_m | (|pend_m)});
            check("R11 irq_out", {31'b0, irq_out}, {31'b0, cfg_m & ~(|pend_m)});
        end
    end

    task automatic do_reset(input logic [1:0] m);
        model_on = 0;
        @(negedge clk);
        rst = 1; mode_sel = m; cs_n = 1; rw_wr_n = 1; ds_rd_n = 1; irq_event = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        split_m = (m == 2'd1) || (m == 2'd3);
        pend_m = 0; cfg_m = 0;
        model_on = 1;
        @(negedge clk);
        check("R9 reset ack_out", {31'b0, ack_out}, 32'd1);
        check("R9 reset data_oe", {31'b0, data_oe}, 32'd0);
    endtask

    // one four-phase cycle; resp = a cycle is expected to run
    task automatic bus(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input logic sel, input bit resp, input logic [7:0] exp_rd,
                       input logic [7:0] ev);
        @(negedge clk);
        cs_n = ~sel; addr = a; data_in = d;
        if (split_m) begin
            if (wr) rw_wr_n = 0; else ds_rd_n = 0;
        end else begin
            rw_wr_n = ~wr; ds_rd_n = 0;
        end
        @(negedge clk);
        @(negedge clk);
        check("R3 ack not early", {31'b0, ack_out}, 32'd1);
        check("R7 no data before ack", {31'b0, data_oe}, 32'd0);
        irq_event = ev;
        @(negedge clk);
        irq_event = 0;
        if (resp) begin
            if (wr) begin
                if (a == 2'd2) pend_m = (pend_m & ~d) | ev;
                else           pend_m = pend_m | ev;
                if (a == 2'd3) cfg_m = d[0];
            end else pend_m = pend_m | ev;
        end else pend_m = pend_m | ev;
        check("R3 ack on third edge", {31'b0, ack_out}, {31'b0, ~resp});
        check("R7 data_oe", {31'b0, data_oe}, {31'b0, resp & sel & ~wr});
        if (resp && sel && !wr) check("R9 read data", {24'b0, data_out}, {24'b0, exp_rd});
        @(negedge clk);
        check("R4 ack held", {31'b0, ack_out}, {31'b0, ~resp});
        rw_wr_n = 1; ds_rd_n = 1;
        @(negedge clk);
        check("R7 data released", {31'b0, data_oe}, 32'd0);
        @(negedge clk);
        check("R4 ack held after release", {31'b0, ack_out}, {31'b0, ~resp});
        @(negedge clk);
        check("R4 ack returns high", {31'b0, ack_out}, 32'd1);
        cs_n = 1;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        irq_event = m;
        @(negedge clk);
        irq_event = 0;
        pend_m = pend_m | m;
    endtask

    initial begin
        // mode 0: data strobe with acknowledge
        do_reset(2'd0);
        check("R6 ack undriven", {31'b0, ack_oe}, 32'd0);
        bus(0, 2'd0, 8'h00, 1, 1, 8'h00, 8'h00);     // R9 reset value
        bus(1, 2'd0, 8'hA5, 1, 1, 8'h00, 8'h00);     // R2 write
        bus(1, 2'd1, 8'h3C, 1, 1, 8'h00, 8'h00);
        bus(0, 2'd0, 8'h00, 1, 1, 8'hA5, 8'h00);     // R2 read
        bus(0, 2'd1, 8'h00, 1, 1, 8'h3C, 8'h00);
        pulse(8'h81);                                 // R10 set, R11 open drain
        bus(0, 2'd2, 8'h00, 1, 1, 8'h81, 8'h00);
        bus(1, 2'd2, 8'h01, 1, 1, 8'h00, 8'h00);     // R10 clear
        bus(0, 2'd2, 8'h00, 1, 1, 8'h80, 8'h00);
        bus(1, 2'd3, 8'h01, 1, 1, 8'h00, 8'h00);     // R11 push-pull
        bus(1, 2'd2, 8'h80, 1, 1, 8'h00, 8'h00);
        bus(0, 2'd3, 8'h00, 1, 1, 8'h01, 8'h00);
        pulse(8'h04);
        bus(1, 2'd2, 8'h04, 1, 1, 8'h00, 8'h04);     // R10 set wins over clear
        bus(0, 2'd2, 8'h00, 1, 1, 8'h04, 8'h00);
        bus(1, 2'd1, 8'h77, 0, 1, 8'h00, 8'h00);     // R8 mode 0 runs deselected
        bus(0, 2'd1, 8'h00, 1, 1, 8'h77, 8'h00);

        // mode 2: data strobe with ready, select required
        do_reset(2'd2);
        bus(1, 2'd0, 8'h5A, 0, 0, 8'h00, 8'h00);     // R8 ignored deselected
        bus(0, 2'd0, 8'h00, 1, 1, 8'h00, 8'h00);
        bus(1, 2'd0, 8'h5A, 1, 1, 8'h00, 8'h00);
        bus(0, 2'd0, 8'h00, 1, 1, 8'h5A, 8'h00);

        // mode 1: split strobes, mode_sel changed after reset (R1)
        do_reset(2'd1);
        mode_sel = 2'd0;
        bus(0, 2'd0, 8'h00, 1, 1, 8'h00, 8'h00);     // R9 cleared by reset
        bus(1, 2'd1, 8'hC3, 1, 1, 8'h00, 8'h00);     // R5 write strobe
        bus(1, 2'd1, 8'h11, 0, 0, 8'h00, 8'h00);     // R5 ignored deselected
        bus(0, 2'd1, 8'h00, 1, 1, 8'hC3, 8'h00);     // R5 read strobe, R1 split kept

        // mode 3 behaves as split
        do_reset(2'd3);
        bus(1, 2'd0, 8'h96, 1, 1, 8'h00, 8'h00);     // R1 code 3
        bus(0, 2'd0, 8'h00, 1, 1, 8'h96, 8'h00);
        bus(1, 2'd0, 8'h01, 0, 0, 8'h00, 8'h00);
        bus(0, 2'd0, 8'h00, 1, 1, 8'h96, 8'h00);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule